// File: doc/BRIEF.md
# Decode-Stage Branch Resolution and Hazard Control

This block is the control logic that lets a five-stage in-order pipeline settle conditional branches while the branch is still in decode. Each cycle it forms the branch target from the decode instruction's PC+4 and its immediate. It picks a bypass source for each of the two comparison operands and tests them for equality. It then either redirects fetch to the target, squashing the one wrongly fetched instruction, or lets the sequential stream run on. The default policy is predict not taken.

Operands are not always ready when the branch reaches decode. The block looks at the destination register, write enable and load/ALU class of the instructions now in EX, MEM and WB. From these it decides how many cycles the branch must wait. It holds the stall itself with a small countdown, so the pipeline only sees a stall flag. The flag freezes the PC and IF/ID and puts a bubble into ID/EX. The register file and the ALU datapath sit outside; the block only receives their values.

Top module: `dec_branch_ctl`

## Requirements
- R1: `redirect_pc` equals `id_pc4` plus the sign-extended `id_imm` shifted left by two, in every cycle, whether or not decode holds a branch.
- R2: When `id_is_br` is 1 and no stall is active, `pc_sel` is 1 exactly when the two forwarded operands are equal over all XLEN bits.
- R3: Each operand's source code is 0 for the register file value, 1 for the EX/MEM bypass (`mem_val`, instruction now in MEM) and 2 for the MEM/WB bypass (`wb_val`, instruction now in WB); code 3 never appears.
- R4: When both MEM and WB write an operand's register, the EX/MEM bypass (code 1) is chosen.
- R5: A branch whose operand is written by an ALU instruction now in EX stalls for exactly one cycle.
- R6: A branch whose operand is written by a load now in EX stalls for exactly two cycles. A load now in MEM causes one stall cycle. Once the countdown has started, the remaining stall cycles occur whatever the hazard inputs show.
- R7: An operand written by an ALU instruction in MEM, or by any instruction in WB, is bypassed with no stall.
- R8: `flush_if` is 1 in exactly the cycles where `pc_sel` is 1.
- R9: Register 0 never selects a bypass and never causes a stall.
- R10: While `stall` is 1, `pc_sel` and `flush_if` are 0. A non-branch in decode never raises `stall`.
- R11: During and right after reset, `stall`, `pc_sel` and `flush_if` are 0 when no branch is in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the stall countdown |
| id_is_br | input | 1 | Decode instruction is a conditional equality branch |
| id_rs | input | 5 | First comparison register number |
| id_rt | input | 5 | Second comparison register number |
| id_rf_a | input | 32 | Register file value for `id_rs` |
| id_rf_b | input | 32 | Register file value for `id_rt` |
| id_pc4 | input | 32 | PC+4 held in IF/ID |
| id_imm | input | 16 | Word offset immediate held in IF/ID |
| ex_wr | input | 1 | Instruction in EX writes a register |
| ex_dst | input | 5 | Destination of the instruction in EX |
| ex_ld | input | 1 | Instruction in EX is a load |
| mem_wr | input | 1 | Instruction in MEM writes a register |
| mem_dst | input | 5 | Destination of the instruction in MEM |
| mem_ld | input | 1 | Instruction in MEM is a load |
| mem_val | input | 32 | Result held in EX/MEM |
| wb_wr | input | 1 | Instruction in WB writes a register |
| wb_dst | input | 5 | Destination of the instruction in WB |
| wb_val | input | 32 | Result held in MEM/WB |
| pc_sel | output | 1 | 1: load `redirect_pc` into the PC |
| redirect_pc | output | 32 | Branch target address |
| stall | output | 1 | Hold PC and IF/ID, insert a bubble into ID/EX |
| flush_if | output | 1 | Clear the control values of the instruction in fetch |
| fwd_a | output | 2 | Source code for the first operand |
| fwd_b | output | 2 | Source code for the second operand |

## Verification
The bench builds the block with its defaults: 32-bit data, 5-bit register numbers, a 16-bit offset, the XNOR-reduction comparator, and stall lengths of one cycle for an ALU producer in EX, two for a load in EX and one for a load in MEM. With these values the full two-cycle load countdown can be reached, including its second cycle, where the hazard inputs are deliberately cleared. The bench also covers the one-cycle cases and both bypass paths with their priority. It covers negative offsets, register 0 posing as a producer, and a non-branch sitting behind a load.

// File: rtl/bdu_pkg.sv
package bdu_pkg;
   typedef enum logic [1:0] {
      SRC_RF    = 2'd0,
      SRC_EXMEM = 2'd1,
      SRC_MEMWB = 2'd2
   } fwd_src_e;
endpackage

// File: rtl/bdu_fwd_pick.sv
module bdu_fwd_pick
   import bdu_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int RAW  = 5
) (
   input  logic [RAW-1:0]  rs,
   input  logic [XLEN-1:0] rf_val,
   input  logic            mem_wr,
   input  logic [RAW-1:0]  mem_dst,
   input  logic [XLEN-1:0] mem_val,
   input  logic            wb_wr,
   input  logic [RAW-1:0]  wb_dst,
   input  logic [XLEN-1:0] wb_val,
   output fwd_src_e        sel,
   output logic [XLEN-1:0] opnd
);
   logic live;
   logic hit_mem, hit_wb;

   assign live    = (rs != '0);
   assign hit_mem = live && mem_wr && (mem_dst == rs);
   assign hit_wb  = live && wb_wr  && (wb_dst  == rs);

   // nearer producer wins
   always_comb begin
      if (hit_mem) begin
         sel  = SRC_EXMEM;
         opnd = mem_val;
      end else if (hit_wb) begin
         sel  = SRC_MEMWB;
         opnd = wb_val;
      end else begin
         sel  = SRC_RF;
         opnd = rf_val;
      end
   end
endmodule

// File: rtl/bdu_eq_cmp.sv
module bdu_eq_cmp #(
   parameter int XLEN  = 32,
   parameter int STYLE = 0
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic            eq
);
   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("bdu_eq_cmp: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_xnor
      logic [XLEN-1:0] same;
      for (genvar i = 0; i < XLEN; i++) begin : g_bit
         assign same[i] = ~(a[i] ^ b[i]);
      end
      assign eq = &same;
   end else begin : g_sub
      logic [XLEN-1:0] diff;
      assign diff = a - b;
      assign eq   = (diff == '0);
   end
endmodule

// File: rtl/bdu_stall_ctl.sv
module bdu_stall_ctl #(
   parameter int RAW         = 5,
   parameter int ALU_EX_HOLD = 1,
   parameter int LD_EX_HOLD  = 2,
   parameter int LD_MEM_HOLD = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           is_br,
   input  logic [RAW-1:0] rs,
   input  logic [RAW-1:0] rt,
   input  logic           ex_wr,
   input  logic [RAW-1:0] ex_dst,
   input  logic           ex_ld,
   input  logic           mem_wr,
   input  logic [RAW-1:0] mem_dst,
   input  logic           mem_ld,
   output logic           stall
);
   localparam int MAXH = (LD_EX_HOLD > ALU_EX_HOLD) ?
                         ((LD_EX_HOLD > LD_MEM_HOLD) ? LD_EX_HOLD : LD_MEM_HOLD) :
                         ((ALU_EX_HOLD > LD_MEM_HOLD) ? ALU_EX_HOLD : LD_MEM_HOLD);
   localparam int CW = $clog2(MAXH + 1);

   if (LD_EX_HOLD < LD_MEM_HOLD || LD_EX_HOLD < ALU_EX_HOLD) begin : g_bad_hold
      $error("bdu_stall_ctl: a load in EX must wait at least as long as any other producer");
   end
   if (MAXH < 1) begin : g_bad_max
      $error("bdu_stall_ctl: at least one hold length must be nonzero");
   end

   logic [RAW-1:0] src [2];
   logic [CW-1:0]  need [2];
   logic [CW-1:0]  need_max;
   logic [CW-1:0]  ctr_q, ctr_d;
   logic           fresh;

   assign src[0] = rs;
   assign src[1] = rt;

   for (genvar k = 0; k < 2; k++) begin : g_opnd
      logic in_ex, in_mem;
      assign in_ex  = (src[k] != '0) && ex_wr  && (ex_dst  == src[k]);
      assign in_mem = (src[k] != '0) && mem_wr && (mem_dst == src[k]) && mem_ld;
      always_comb begin
         if (in_ex)       need[k] = ex_ld ? CW'(LD_EX_HOLD) : CW'(ALU_EX_HOLD);
         else if (in_mem) need[k] = CW'(LD_MEM_HOLD);
         else             need[k] = '0;
      end
   end

   assign need_max = (need[0] > need[1]) ? need[0] : need[1];
   assign fresh    = is_br && (ctr_q == '0) && (need_max != '0);
   assign stall    = (ctr_q != '0) || fresh;

   always_comb begin
      if (ctr_q != '0) ctr_d = ctr_q - 1'b1;
      else if (fresh)  ctr_d = need_max - 1'b1;
      else             ctr_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctr_q <= '0;
      else        ctr_q <= ctr_d;
   end

   // a running countdown steps down by one each cycle
   p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_q != '0) |=> (ctr_q == $past(ctr_q) - 1'b1));

   // a non-branch with no countdown running is never held
   p_nonbr_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_br && ctr_q == '0) |-> !stall);

   if (LD_EX_HOLD > 1) begin : g_ld_chk
      // a load in EX feeding the branch keeps it held into the next cycle
      p_ld_ex_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (is_br && ctr_q == '0 && ex_wr && ex_ld && ex_dst != '0 &&
          (ex_dst == rs || ex_dst == rt)) |=> stall);
   end
endmodule

// File: rtl/dec_branch_ctl.sv
module dec_branch_ctl
   import bdu_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int RAW         = 5,
   parameter int IMM_W       = 16,
   parameter int CMP_STYLE   = 0,
   parameter int ALU_EX_HOLD = 1,
   parameter int LD_EX_HOLD  = 2,
   parameter int LD_MEM_HOLD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             id_is_br,
   input  logic [RAW-1:0]   id_rs,
   input  logic [RAW-1:0]   id_rt,
   input  logic [XLEN-1:0]  id_rf_a,
   input  logic [XLEN-1:0]  id_rf_b,
   input  logic [XLEN-1:0]  id_pc4,
   input  logic [IMM_W-1:0] id_imm,
   input  logic             ex_wr,
   input  logic [RAW-1:0]   ex_dst,
   input  logic             ex_ld,
   input  logic             mem_wr,
   input  logic [RAW-1:0]   mem_dst,
   input  logic             mem_ld,
   input  logic [XLEN-1:0]  mem_val,
   input  logic             wb_wr,
   input  logic [RAW-1:0]   wb_dst,
   input  logic [XLEN-1:0]  wb_val,
   output logic             pc_sel,
   output logic [XLEN-1:0]  redirect_pc,
   output logic             stall,
   output logic             flush_if,
   output logic [1:0]       fwd_a,
   output logic [1:0]       fwd_b
);
   localparam int EXT_W = XLEN - IMM_W - 2;

   if (EXT_W < 0) begin : g_bad_imm
      $error("dec_branch_ctl: XLEN must be at least IMM_W + 2");
   end
   if (RAW < 1) begin : g_bad_raw
      $error("dec_branch_ctl: RAW must be positive");
   end

   fwd_src_e        sel [2];
   logic [XLEN-1:0] opv [2];
   logic [RAW-1:0]  reg_no [2];
   logic [XLEN-1:0] rf_v [2];
   logic [XLEN-1:0] byte_off;
   logic            same;
   logic            taken;

   assign reg_no[0] = id_rs;
   assign reg_no[1] = id_rt;
   assign rf_v[0]   = id_rf_a;
   assign rf_v[1]   = id_rf_b;

   for (genvar k = 0; k < 2; k++) begin : g_fwd
      bdu_fwd_pick #(.XLEN(XLEN), .RAW(RAW)) u_pick (
         .rs      (reg_no[k]),
         .rf_val  (rf_v[k]),
         .mem_wr  (mem_wr),
         .mem_dst (mem_dst),
         .mem_val (mem_val),
         .wb_wr   (wb_wr),
         .wb_dst  (wb_dst),
         .wb_val  (wb_val),
         .sel     (sel[k]),
         .opnd    (opv[k])
      );
   end

   bdu_eq_cmp #(.XLEN(XLEN), .STYLE(CMP_STYLE)) u_cmp (
      .a  (opv[0]),
      .b  (opv[1]),
      .eq (same)
   );

   bdu_stall_ctl #(
      .RAW(RAW), .ALU_EX_HOLD(ALU_EX_HOLD),
      .LD_EX_HOLD(LD_EX_HOLD), .LD_MEM_HOLD(LD_MEM_HOLD)
   ) u_stall (
      .clk     (clk),
      .rst_n   (rst_n),
      .is_br   (id_is_br),
      .rs      (id_rs),
      .rt      (id_rt),
      .ex_wr   (ex_wr),
      .ex_dst  (ex_dst),
      .ex_ld   (ex_ld),
      .mem_wr  (mem_wr),
      .mem_dst (mem_dst),
      .mem_ld  (mem_ld),
      .stall   (stall)
   );

   // target formed every cycle; only consumed on a taken branch
   if (EXT_W > 0) begin : g_ext
      assign byte_off = {{EXT_W{id_imm[IMM_W-1]}}, id_imm, 2'b00};
   end else begin : g_noext
      assign byte_off = {id_imm, 2'b00};
   end
   assign redirect_pc = id_pc4 + byte_off;

   assign taken    = id_is_br && !stall && same;
   assign pc_sel   = taken;
   assign flush_if = taken;
   assign fwd_a    = sel[0];
   assign fwd_b    = sel[1];

   // no redirect while the branch is held
   p_hold_no_redir_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (!pc_sel && !flush_if));

   // a redirect only comes from a branch in decode
   p_redir_br_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pc_sel |-> id_is_br);

   // source codes stay in the defined set
   p_src_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a != 2'd3) && (fwd_b != 2'd3));

   // register 0 is never bypassed
   p_zero_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((id_rs == '0) |-> (fwd_a == 2'd0)) and ((id_rt == '0) |-> (fwd_b == 2'd0)));

   // EX/MEM beats MEM/WB
   p_mem_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && id_rs != '0 && mem_dst == id_rs) |-> (fwd_a == 2'd1));
endmodule

// File: tb/tb_dec_branch_ctl.sv
module tb_dec_branch_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        id_is_br;
   logic [4:0]  id_rs, id_rt, ex_dst, mem_dst, wb_dst;
   logic [31:0] id_rf_a, id_rf_b, id_pc4, mem_val, wb_val;
   logic [15:0] id_imm;
   logic        ex_wr, ex_ld, mem_wr, mem_ld, wb_wr;
   logic        pc_sel, stall, flush_if;
   logic [31:0] redirect_pc;
   logic [1:0]  fwd_a, fwd_b;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dec_branch_ctl dut (.*);

   typedef struct {
      string       tag;
      logic        stl, sel, fl;
      logic [31:0] tgt;
      logic [1:0]  fa, fb;
   } exp_t;
   exp_t q[$];

   function automatic logic [31:0] tgt_of(logic [31:0] pc4, logic [15:0] imm);
      return pc4 + {{14{imm[15]}}, imm, 2'b00};
   endfunction

   task automatic nxt();
      @(negedge clk);
      id_is_br = 0; id_rs = 0; id_rt = 0; id_rf_a = 0; id_rf_b = 0;
      id_pc4 = 32'h100; id_imm = 16'h0010;
      ex_wr = 0; ex_dst = 0; ex_ld = 0;
      mem_wr = 0; mem_dst = 0; mem_ld = 0; mem_val = 0;
      wb_wr = 0; wb_dst = 0; wb_val = 0;
   endtask

   // driver side: record what the current inputs must produce
   task automatic expect_out(string tag, logic s, logic t, logic [1:0] fa, logic [1:0] fb);
      exp_t e;
      e.tag = tag; e.stl = s; e.sel = t; e.fl = t;
      e.tgt = tgt_of(id_pc4, id_imm); e.fa = fa; e.fb = fb;
      q.push_back(e);
   endtask

   // monitor: sample mid-cycle, away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (stall !== e.stl || pc_sel !== e.sel || flush_if !== e.fl ||
                redirect_pc !== e.tgt || fwd_a !== e.fa || fwd_b !== e.fb) begin
               n_err++;
               $display("FAIL %s: got stall=%0b sel=%0b flush=%0b pc=%h fa=%0d fb=%0d exp stall=%0b sel=%0b flush=%0b pc=%h fa=%0d fb=%0d",
                        e.tag, stall, pc_sel, flush_if, redirect_pc, fwd_a, fwd_b,
                        e.stl, e.sel, e.fl, e.tgt, e.fa, e.fb);
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      // R11 reset state
      nxt(); expect_out("R11 in reset", 0, 0, 0, 0);
      nxt(); expect_out("R11 in reset 2", 0, 0, 0, 0);
      rst_n = 1'b1;
      nxt(); expect_out("R11 after reset", 0, 0, 0, 0);

      // R1 target: positive and negative offset, non-branch
      nxt(); id_pc4 = 32'd44; id_imm = 16'd7; expect_out("R1 pos offset", 0, 0, 0, 0);
      nxt(); id_pc4 = 32'd100; id_imm = 16'hFFFE; expect_out("R1 neg offset", 0, 0, 0, 0);

      // R2 and R8: taken and not taken from register file
      nxt(); id_is_br = 1; id_rs = 1; id_rt = 3; id_rf_a = 32'h55; id_rf_b = 32'h55;
      expect_out("R2 R8 taken", 0, 1, 0, 0);
      nxt(); id_is_br = 1; id_rs = 1; id_rt = 3; id_rf_a = 32'h55; id_rf_b = 32'h8000_0055;
      expect_out("R2 R8 not taken top bit", 0, 0, 0, 0);

      // R3 both bypass paths, taken through them
      nxt(); id_is_br = 1; id_rs = 2; id_rt = 4; id_rf_a = 1; id_rf_b = 2;
      mem_wr = 1; mem_dst = 2; mem_val = 9; wb_wr = 1; wb_dst = 4; wb_val = 9;
      expect_out("R3 R7 exmem and memwb", 0, 1, 1, 2);

      // R4 priority: MEM value wins over WB
      nxt(); id_is_br = 1; id_rs = 2; id_rt = 5; id_rf_a = 0; id_rf_b = 9;
      mem_wr = 1; mem_dst = 2; mem_val = 9; wb_wr = 1; wb_dst = 2; wb_val = 1;
      expect_out("R4 exmem over memwb", 0, 1, 1, 0);

      // R9 register 0 with producers naming it
      nxt(); id_is_br = 1; id_rs = 0; id_rt = 0;
      ex_wr = 1; ex_dst = 0; ex_ld = 1; mem_wr = 1; mem_dst = 0; mem_val = 7;
      wb_wr = 1; wb_dst = 0; wb_val = 3;
      expect_out("R9 r0 no bypass no stall", 0, 1, 0, 0);

      // R5 ALU in EX: one stall, then bypass from EX/MEM
      nxt(); id_is_br = 1; id_rs = 1; id_rt = 3; id_rf_a = 4; id_rf_b = 4;
      ex_wr = 1; ex_dst = 1; ex_ld = 0;
      expect_out("R5 R10 alu in ex holds", 1, 0, 0, 0);
      nxt(); id_is_br = 1; id_rs = 1; id_rt = 3; id_rf_a = 0; id_rf_b = 4;
      mem_wr = 1; mem_dst = 1; mem_ld = 0; mem_val = 4;
      expect_out("R5 R7 alu in mem released", 0, 1, 1, 0);

      // R6 load in EX: two stalls, second with hazard inputs cleared
      nxt(); id_is_br = 1; id_rs = 6; id_rt = 1; id_rf_a = 8; id_rf_b = 8;
      ex_wr = 1; ex_dst = 1; ex_ld = 1;
      expect_out("R6 load in ex cycle 1", 1, 0, 0, 0);
      nxt(); id_is_br = 1; id_rs = 6; id_rt = 1; id_rf_a = 8; id_rf_b = 8;
      expect_out("R6 load in ex cycle 2 countdown", 1, 0, 0, 0);
      nxt(); id_is_br = 1; id_rs = 6; id_rt = 1; id_rf_a = 8; id_rf_b = 0;
      wb_wr = 1; wb_dst = 1; wb_val = 8;
      expect_out("R6 R7 load in wb released", 0, 1, 0, 2);

      // R6 load in MEM: one stall
      nxt(); id_is_br = 1; id_rs = 7; id_rt = 0; id_rf_a = 0;
      mem_wr = 1; mem_dst = 7; mem_ld = 1; mem_val = 5;
      expect_out("R6 load in mem holds", 1, 0, 1, 0);
      nxt(); id_is_br = 1; id_rs = 7; id_rt = 0; id_rf_a = 3;
      wb_wr = 1; wb_dst = 7; wb_val = 5;
      expect_out("R6 load in mem one cycle only", 0, 0, 2, 0);

      // R10 non-branch behind a load never stalls
      nxt(); id_is_br = 0; id_rs = 1; id_rt = 2;
      ex_wr = 1; ex_dst = 1; ex_ld = 1;
      expect_out("R10 non-branch no stall", 0, 0, 0, 0);
      nxt(); expect_out("R10 after non-branch", 0, 0, 0, 0);

      nxt();
      nxt();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule